// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a calendar/time counter chain and raises an alarm when the time reaches a programmed value. Up to six alarm bytes are held in registers that a host reaches over a simple write-strobe register bus. Each alarm byte has its own compare enable. An enabled byte must equal its counter byte. A disabled byte counts as equal, so a subset of bytes can be compared. With only hours and the faster bytes enabled, the result is a daily alarm; with only minutes and the faster bytes, an hourly one.

The comparison is evaluated only in a cycle where the counter chain presents an updated value, marked by a tick strobe. A match sets a sticky status flag. The flag sets whatever the interrupt enable is. The interrupt request output is the flag gated by an alarm interrupt enable. The host clears the flag by writing a one to bit 3 of the status register. A disabled byte's register stays fully usable as general storage.

Top module: `alarm_match_unit`

## Requirements
- R1: Alarm byte i (0 to 5) is written and read at bus address i. It reads back the last value written whether or not its compare is enabled.
- R2: Address 6 holds the compare enables in bits [5:0], where bit i enables byte i. Address 7 holds the alarm interrupt enable in bit 0. Address 8 is the status register, with the alarm flag in bit 3. Unimplemented bits read as zero.
- R3: When the tick input is high and every enabled alarm byte equals its counter byte, the flag is set from the next cycle on. Counter byte i is cnt_time_i[8i+7:8i].
- R4: A disabled byte never blocks a match. With all enables clear, every tick sets the flag.
- R5: The flag does not set in a cycle with no tick, even when the bytes match. It does not set on a tick where any enabled byte differs.
- R6: Once set, the flag stays set until it is cleared. It is visible on alm_flag_o and in status bit 3.
- R7: A bus write to address 8 with data bit 3 high clears the flag in the next cycle. The same write with bit 3 low leaves the flag as it was.
- R8: If a clear write and a matching tick fall in the same cycle, the flag is set afterwards.
- R9: alm_irq_o is high exactly when the flag and the interrupt enable are both set. The flag sets whatever the interrupt enable is.
- R10: After reset, all alarm bytes, the enables, the interrupt enable and the flag are zero.
- R11: With hours=03, minutes=15 and hundredths and seconds at 00, and those four bytes enabled, the alarm fires on the tick that moves the time from 03:14:59.99 to 03:15:00.00, and not on the tick before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick_i | input | 1 | High for one cycle when cnt_time_i holds a new count |
| cnt_time_i | input | 48 | Live BCD counter bytes, byte i in bits [8i+7:8i] |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| alm_flag_o | output | 1 | Sticky alarm status flag |
| alm_irq_o | output | 1 | Alarm interrupt request (flag gated by enable) |

## Verification
A clear write to the status register and a matching tick can fall in the same cycle. The bench provokes this by raising the tick with matching counter bytes in the same cycle as the write-one-to-clear. It judges the result by requiring the flag to read as set on the following cycle. It also clears a set flag with no tick present and checks that it drops. In the main sweep, every enable mask is paired with every pattern of mismatching bytes. The expected flag is computed in the bench as "no mismatching byte is enabled".

// File: rtl/alm_pkg.sv
// Package: alm_pkg
// Shared sizing defaults for the alarm comparator. Assumes the number of
// alarm bytes never exceeds the register data width, so the enable
// register fits in a single bus word.
package alm_pkg;
    localparam int unsigned ALM_NUM_BYTES = 6;
    localparam int unsigned ALM_BYTE_W    = 8;
    localparam int unsigned ALM_ADDR_W    = 4;
    localparam int unsigned ALM_FLAG_BIT  = 3;
endpackage

// File: rtl/alm_regs.sv
// Module: alm_regs
// Host-visible register file. It holds the alarm bytes, the per-byte compare
// enables and the interrupt enable, and it produces the read data mux.
// It also decodes a write-one-to-clear request for the status flag.
// Assumes NUM_BYTES <= BYTE_W. Addresses are placed as follows: the alarm
// bytes come first, then enables, then control, then status.
module alm_regs #(
    parameter int unsigned NUM_BYTES = alm_pkg::ALM_NUM_BYTES,
    parameter int unsigned BYTE_W    = alm_pkg::ALM_BYTE_W,
    parameter int unsigned ADDR_W    = alm_pkg::ALM_ADDR_W,
    parameter int unsigned FLAG_BIT  = alm_pkg::ALM_FLAG_BIT
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [BYTE_W-1:0]                  wdata_i,
    input  logic                               flag_i,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0]   alarm_o,
    output logic [NUM_BYTES-1:0]               cmp_en_o,
    output logic                               irq_en_o,
    output logic                               clr_req_o,
    output logic [BYTE_W-1:0]                  rdata_o
);
    localparam logic [ADDR_W-1:0] ADR_EN   = ADDR_W'(NUM_BYTES);
    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(NUM_BYTES + 1);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(NUM_BYTES + 2);

    logic [NUM_BYTES-1:0][BYTE_W-1:0] alarm_q;
    logic [NUM_BYTES-1:0]             cmp_en_q;
    logic                             irq_en_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
            // Holds one alarm byte; writable whatever its enable is.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alarm_q[gi] <= '0;
                else if (wr_i && addr_i == ADDR_W'(gi))
                    alarm_q[gi] <= wdata_i;
            end

            // R1: a write to this byte is visible on the next cycle
            assert_byte_store_R1: assert property (
                @(posedge clk) disable iff (!rst_n)
                (wr_i && addr_i == ADDR_W'(gi)) |=> (alarm_q[gi] == $past(wdata_i))
            );
        end
    endgenerate

    // Holds the per-byte compare enables.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_en_q <= '0;
        else if (wr_i && addr_i == ADR_EN)
            cmp_en_q <= wdata_i[NUM_BYTES-1:0];
    end

    // Holds the alarm interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en_q <= 1'b0;
        else if (wr_i && addr_i == ADR_CTRL)
            irq_en_q <= wdata_i[0];
    end

    // Selects read data; unimplemented bits and addresses read as zero.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < int'(NUM_BYTES); i++) begin
            if (addr_i == ADDR_W'(i))
                rdata_o = alarm_q[i];
        end
        if (addr_i == ADR_EN)
            rdata_o[NUM_BYTES-1:0] = cmp_en_q;
        if (addr_i == ADR_CTRL)
            rdata_o[0] = irq_en_q;
        if (addr_i == ADR_STAT)
            rdata_o[FLAG_BIT] = flag_i;
    end

    // Decodes the write-one-to-clear request for the status flag.
    always_comb begin
        clr_req_o = wr_i && (addr_i == ADR_STAT) && wdata_i[FLAG_BIT];
    end

    assign alarm_o  = alarm_q;
    assign cmp_en_o = cmp_en_q;
    assign irq_en_o = irq_en_q;

    // R2: enables change only on a write to their address
    assert_en_stable_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADR_EN) |=> $stable(cmp_en_q)
    );
endmodule

// File: rtl/alm_cmp.sv
// Module: alm_cmp
// Masked equality of the alarm bytes against the live counter bytes.
// A disabled byte acts as an always-equal comparator. The result is purely
// combinational; the counter chain is assumed stable while the tick is high.
module alm_cmp #(
    parameter int unsigned NUM_BYTES = alm_pkg::ALM_NUM_BYTES,
    parameter int unsigned BYTE_W    = alm_pkg::ALM_BYTE_W
) (
    input  logic [NUM_BYTES-1:0][BYTE_W-1:0] alarm_i,
    input  logic [NUM_BYTES*BYTE_W-1:0]      cnt_i,
    input  logic [NUM_BYTES-1:0]             cmp_en_i,
    output logic                             all_eq_o
);
    logic [NUM_BYTES-1:0] byte_ok;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BYTES; gi++) begin : g_cmp
            // One byte comparator, forced equal when its enable is clear.
            always_comb begin
                byte_ok[gi] = !cmp_en_i[gi] ||
                              (alarm_i[gi] == cnt_i[gi*BYTE_W +: BYTE_W]);
            end
        end
    endgenerate

    // Combines all byte results.
    always_comb begin
        all_eq_o = &byte_ok;
    end

    // R4: with no byte enabled the comparator always reports a match
    always_comb begin
        assert_all_masked_R4: assert (!(cmp_en_i == '0) || all_eq_o);
    end
endmodule

// File: rtl/alm_flag.sv
// Module: alm_flag
// Sticky alarm status flag with write-one-to-clear and interrupt gating.
// The comparison result is sampled only on a counter tick. A set in the same
// cycle as a clear wins.
module alm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic all_eq_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;
    logic set_now;

    // Qualifies the match with the counter update strobe.
    always_comb begin
        set_now = tick_i && all_eq_i;
    end

    // Holds the sticky flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_now)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    // Gates the interrupt request with its enable.
    always_comb begin
        irq_o = flag_q && irq_en_i;
    end

    assign flag_o = flag_q;

    // R3: a ticked match sets the flag
    assert_set_on_match_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tick_i && all_eq_i) |=> flag_q
    );
    // R5: without a ticked match the flag cannot rise
    assert_no_spurious_set_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!flag_q && !(tick_i && all_eq_i)) |=> !flag_q
    );
    // R6: the flag holds until a clear
    assert_sticky_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q
    );
    // R7: a clear with no ticked match drops the flag
    assert_clear_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (clr_i && !(tick_i && all_eq_i)) |=> !flag_q
    );
    // R8: simultaneous set and clear leaves the flag set
    assert_set_wins_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (clr_i && tick_i && all_eq_i) |=> flag_q
    );
endmodule

// File: rtl/alarm_match_unit.sv
// Module: alarm_match_unit
// Top of the masked BCD alarm comparator. It ties together the register file,
// the masked byte comparator and the sticky flag. The counter chain is
// external; cnt_tick_i must be high for one cycle with the new count.
module alarm_match_unit #(
    parameter int unsigned NUM_BYTES = alm_pkg::ALM_NUM_BYTES,
    parameter int unsigned BYTE_W    = alm_pkg::ALM_BYTE_W,
    parameter int unsigned ADDR_W    = alm_pkg::ALM_ADDR_W,
    parameter int unsigned FLAG_BIT  = alm_pkg::ALM_FLAG_BIT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_tick_i,
    input  logic [NUM_BYTES*BYTE_W-1:0] cnt_time_i,
    input  logic                        bus_wr_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [BYTE_W-1:0]           bus_wdata_i,
    output logic [BYTE_W-1:0]           bus_rdata_o,
    output logic                        alm_flag_o,
    output logic                        alm_irq_o
);
    logic [NUM_BYTES-1:0][BYTE_W-1:0] alarm_w;
    logic [NUM_BYTES-1:0]             cmp_en_w;
    logic                             irq_en_w;
    logic                             clr_w;
    logic                             all_eq_w;
    logic                             flag_w;
    logic                             irq_w;

    alm_regs #(
        .NUM_BYTES (NUM_BYTES),
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W),
        .FLAG_BIT  (FLAG_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .flag_i    (flag_w),
        .alarm_o   (alarm_w),
        .cmp_en_o  (cmp_en_w),
        .irq_en_o  (irq_en_w),
        .clr_req_o (clr_w),
        .rdata_o   (bus_rdata_o)
    );

    alm_cmp #(
        .NUM_BYTES (NUM_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_cmp (
        .alarm_i   (alarm_w),
        .cnt_i     (cnt_time_i),
        .cmp_en_i  (cmp_en_w),
        .all_eq_o  (all_eq_w)
    );

    alm_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (cnt_tick_i),
        .all_eq_i  (all_eq_w),
        .clr_i     (clr_w),
        .irq_en_i  (irq_en_w),
        .flag_o    (flag_w),
        .irq_o     (irq_w)
    );

    assign alm_flag_o = flag_w;
    assign alm_irq_o  = irq_w;

    // R9: no interrupt request while the enable is clear
    assert_irq_masked_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !irq_en_w |-> !alm_irq_o
    );
    // R10: state is cleared one cycle after reset is applied
    assert_reset_clear_R10: assert property (
        @(posedge clk)
        !rst_n |=> (!alm_flag_o && !alm_irq_o)
    );
endmodule

// File: tb/alarm_match_unit_test.sv
`timescale 1ns/1ps
module alarm_match_unit_test;
    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [47:0] cnt = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        flag;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alarm_match_unit uut (
        .clk(clk), .rst_n(rst_n), .cnt_tick_i(tick), .cnt_time_i(cnt),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .alm_flag_o(flag), .alm_irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_tick(input logic [47:0] t);
        @(negedge clk);
        tick = 1'b1; cnt = t;
        @(negedge clk);
        tick = 1'b0;
    endtask

    function automatic logic [7:0] base_byte(input int i);
        return 8'(8'h11 * (i + 1));
    endfunction

    function automatic logic [47:0] mk_time(input int diff);
        logic [47:0] v;
        for (int i = 0; i < NB; i++)
            v[8*i +: 8] = base_byte(i) ^ (diff[i] ? 8'h01 : 8'h00);
        return v;
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int a = 0; a < 9; a++) begin
            bus_read(4'(a), rd);
            chk("R10 reg after reset", rd, 0);
        end
        chk("R10 flag after reset", flag, 0);
        chk("R10 irq after reset", irq, 0);

        // R2: enable and control registers mask unimplemented bits
        bus_write(4'd6, 8'hFF);
        bus_read(4'd6, rd); chk("R2 enable readback", rd, 8'h3F);
        bus_write(4'd7, 8'hFF);
        bus_read(4'd7, rd); chk("R2 control readback", rd, 8'h01);
        bus_write(4'd7, 8'h00);
        bus_write(4'd6, 8'h00);

        // R1: disabled bytes act as storage
        for (int i = 0; i < NB; i++) begin
            bus_write(4'(i), 8'hA5 ^ 8'(i));
            bus_read(4'(i), rd); chk("R1 storage readback", rd, 8'hA5 ^ 8'(i));
        end

        // R4: all disabled -> every tick sets the flag
        do_tick(48'h0);
        chk("R4 all masked tick sets", flag, 1);
        bus_write(4'd8, 8'h08);
        chk("R7 clear", flag, 0);
        bus_read(4'd8, rd); chk("R7 status bit3 low", rd, 0);

        // load sweep alarm bytes
        for (int i = 0; i < NB; i++) bus_write(4'(i), base_byte(i));

        // R3/R4/R5: sweep every enable mask against every mismatch pattern
        for (int m = 0; m < 64; m++) begin
            bus_write(4'd6, 8'(m));
            for (int d = 0; d < 64; d++) begin
                do_tick(mk_time(d));
                chk("R3 R4 R5 sweep flag", flag, ((d & m) == 0) ? 1 : 0);
                if (flag) bus_write(4'd8, 8'h08);
            end
        end

        // R5: matching value without tick does not set
        bus_write(4'd6, 8'h3F);
        @(negedge clk); cnt = mk_time(0);
        repeat (4) @(negedge clk);
        chk("R5 no tick no set", flag, 0);

        // R6: sticky across non-matching ticks, visible in status bit3
        do_tick(mk_time(0));
        do_tick(mk_time(5));
        repeat (3) @(negedge clk);
        chk("R6 flag sticky", flag, 1);
        bus_read(4'd8, rd); chk("R6 status bit3", rd, 8'h08);

        // R7: write with bit3 low does not clear
        bus_write(4'd8, 8'hF7);
        chk("R7 bit3 low keeps flag", flag, 1);

        // R9: irq gating
        chk("R9 irq masked with flag set", irq, 0);
        bus_write(4'd7, 8'h01);
        chk("R9 irq when enabled", irq, 1);
        bus_write(4'd8, 8'h08);
        chk("R9 irq drops with flag", irq, 0);

        // R8: clear and matching tick in the same cycle
        do_tick(mk_time(0));
        @(negedge clk);
        wr = 1'b1; addr = 4'd8; wdata = 8'h08; tick = 1'b1; cnt = mk_time(0);
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        chk("R8 set wins over clear", flag, 1);
        chk("R8 irq follows", irq, 1);
        bus_write(4'd8, 8'h08);
        chk("R7 clear after collision", flag, 0);
        bus_write(4'd7, 8'h00);

        // R11: daily alarm at 03:15:00.00 (byte0 hundredths .. byte3 hours)
        bus_write(4'd0, 8'h00);
        bus_write(4'd1, 8'h00);
        bus_write(4'd2, 8'h15);
        bus_write(4'd3, 8'h03);
        bus_write(4'd6, 8'h0F);
        do_tick(48'h0712_0314_5998);
        chk("R11 no alarm at 03:14:59.98", flag, 0);
        do_tick(48'h0712_0314_5999);
        chk("R11 no alarm at 03:14:59.99", flag, 0);
        do_tick(48'h0712_0315_0000);
        chk("R11 alarm at 03:15:00.00", flag, 1);
        bus_write(4'd8, 8'h08);
        do_tick(48'h0712_0315_0001);
        chk("R11 no alarm at 03:15:00.01", flag, 0);
        do_tick(48'h0913_0315_0000);
        chk("R11 next day fires again", flag, 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule